// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Match Interrupt

This block is a real-time-clock peripheral on a simple 32-bit register bus. A prescaler divides the input clock down to a single-cycle tick once every `PRESCALE_DIV` clocks. On each tick, a seconds counter of up to 32 bits moves one step forward. When the counter reaches the value held in the match register, the block latches a raw interrupt flag. The interrupt output is that flag gated by an enable bit and a mask bit.

Software sets the time through a load register. A written load value is held pending and is copied into the counter on the next tick, not on the write cycle. Software acknowledges an interrupt by reading the acknowledge register. That read is the clear, and writes to that register do nothing. A control bit chooses whether the counter stops at its all-ones value or wraps to zero.

The bus uses word addressing. `bus_addr` is the word index, so byte offset = 4 × index. Read data is registered and is valid in the cycle after the read strobe.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the counter, match, load, control and both status registers read as 0, and `irq_o` is low.
- R2: While control bit 2 (run) is 1, the counter (word 0) increases by one every `PRESCALE_DIV` clocks. While run is 0, the counter holds its value.
- R3: A write to word 2 (load) does not change the counter until the next tick. On that tick the counter takes the written value. Word 2 reads back the last value written.
- R4: At the all-ones value, the counter holds on a tick when control bit 3 (wrap) is 0, and rolls to 0 when wrap is 1.
- R5: Bit 0 of word 5 (raw status) is set on the tick at which the counter takes a value equal to word 1 (match). This happens whatever the control bits are.
- R6: Bit 0 of word 4 (masked status) and `irq_o` both equal raw AND control bit 0 (enable) AND NOT control bit 1 (mask).
- R7: A read of word 6 clears the raw status and returns 0. A write to word 6 has no effect. If a set and the clear happen in the same cycle, the set wins.
- R8: Word 7 returns the `VERSION` parameter. Writes to words 0, 4, 5 and 7 are ignored.
- R9: Reads of words 8 to 15 return 0. Read data appears exactly one clock after the read strobe.
- R10: Word 3 reads back control bits 3:0, and bits 31:4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write lands at the clock edge that samples the strobe. Read data, and the clear caused by an acknowledge read, appear one edge later. A load or a counter step becomes visible only at the edge where the prescaler reaches `PRESCALE_DIV-1` with run set. The bench keeps a per-edge reference model, advanced in the same stepping task that drives the bus. It samples `bus_rdata` and `irq_o` at the falling edge after the sampling edge, so every comparison targets the exact cycle the requirements define. Random accesses, biased towards match values just ahead of the counter and loads near all-ones, are mixed with directed sequences for reset, delayed load, hold and wrap, masking and acknowledge.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  // Word indices of the register window
  localparam int IX_COUNT   = 0;
  localparam int IX_MATCH   = 1;
  localparam int IX_LOAD    = 2;
  localparam int IX_CTRL    = 3;
  localparam int IX_MSTAT   = 4;
  localparam int IX_RSTAT   = 5;
  localparam int IX_ACK     = 6;
  localparam int IX_VERSION = 7;
  localparam int NUM_REGS   = 8;

  // Control bit positions
  localparam int CB_IE   = 0;
  localparam int CB_MASK = 1;
  localparam int CB_RUN  = 2;
  localparam int CB_WRAP = 3;
  localparam int CTRL_W  = 4;
endpackage

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q;

  assign tick_o = run_i && (pc_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (!run_i) pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] next_o,
  output logic [CNT_W-1:0] load_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, load_q;
  logic             pend_q;

  always_comb begin
    if (pend_q)                      next_o = load_q;
    else if (cnt_q == TOP && !wrap_i) next_o = cnt_q;
    else                             next_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick_i) begin
        cnt_q  <= next_o;
        pend_q <= 1'b0;
      end
      if (load_we_i) begin
        load_q <= load_val_i;
        pend_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;

  // R3
  load_deferred_chk: assert property (@(posedge clk) disable iff (rst)
    (load_we_i && !tick_i) |=> $stable(cnt_o));

  // R4
  top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !pend_q && !wrap_i && cnt_q == TOP) |=> (cnt_o == TOP));

  // R4
  top_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !pend_q && wrap_i && cnt_q == TOP) |=> (cnt_o == '0));
endmodule

// File: rtl/sec_rtc_status.sv
module sec_rtc_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic mask_i,
  output logic raw_o,
  output logic masked_o
);
  logic raw_q;

  always_ff @(posedge clk) begin
    if (rst)        raw_q <= 1'b0;
    else if (set_i) raw_q <= 1'b1;
    else if (clr_i) raw_q <= 1'b0;
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & ie_i & ~mask_i;

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !raw_o);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> raw_o);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int          PRESCALE_DIV = 32768,
  parameter int          CNT_W        = 32,
  parameter int          ADDR_W       = 4,
  parameter logic [31:0] VERSION      = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  import sec_rtc_pkg::*;

  localparam int DATA_W = 32;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  match_q;
  logic [CNT_W-1:0]  cnt, cnt_next, load_rb;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic              tick, raw, masked;
  logic              sel_match, sel_load, sel_ctrl, sel_ack, hit;

  assign sel_match = (bus_addr == ADDR_W'(IX_MATCH));
  assign sel_load  = (bus_addr == ADDR_W'(IX_LOAD));
  assign sel_ctrl  = (bus_addr == ADDR_W'(IX_CTRL));
  assign sel_ack   = (bus_addr == ADDR_W'(IX_ACK));
  assign hit       = tick && (cnt_next == match_q);

  sec_rtc_prescale #(.DIV(PRESCALE_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_i  (ctrl_q[CB_RUN]),
    .tick_o (tick)
  );

  sec_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .wrap_i     (ctrl_q[CB_WRAP]),
    .load_we_i  (bus_wr && sel_load),
    .load_val_i (bus_wdata[CNT_W-1:0]),
    .cnt_o      (cnt),
    .next_o     (cnt_next),
    .load_o     (load_rb)
  );

  sec_rtc_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_i    (hit),
    .clr_i    (bus_rd && sel_ack),
    .ie_i     (ctrl_q[CB_IE]),
    .mask_i   (ctrl_q[CB_MASK]),
    .raw_o    (raw),
    .masked_o (masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      match_q <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
      if (sel_match) match_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (int'(bus_addr))
      IX_COUNT:   rd_val = DATA_W'(cnt);
      IX_MATCH:   rd_val = DATA_W'(match_q);
      IX_LOAD:    rd_val = DATA_W'(load_rb);
      IX_CTRL:    rd_val = DATA_W'(ctrl_q);
      IX_MSTAT:   rd_val = DATA_W'(masked);
      IX_RSTAT:   rd_val = DATA_W'(raw);
      IX_VERSION: rd_val = VERSION;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = masked;

  // R5
  match_sets_raw_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> raw);

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CB_IE] || ctrl_q[CB_MASK]) |-> !irq_o);

  // R2
  halted_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CB_RUN] |=> $stable(cnt));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) >= NUM_REGS) |=> (bus_rdata == '0));
endmodule

// File: tb/sec_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_tb_top;
  localparam int          DIV = 4;
  localparam logic [31:0] VER = 32'hA5C3_0102;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_cnt, m_match, m_load;
  logic        m_pend, m_raw;
  logic [3:0]  m_ctrl;
  int          m_pc;

  always #5 clk = ~clk;

  sec_rtc #(.PRESCALE_DIV(DIV), .CNT_W(32), .ADDR_W(4), .VERSION(VER)) dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return m_cnt;
      4'd1: return m_match;
      4'd2: return m_load;
      4'd3: return {28'd0, m_ctrl};
      4'd4: return {31'd0, m_raw & m_ctrl[0] & ~m_ctrl[1]};
      4'd5: return {31'd0, m_raw};
      4'd7: return VER;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_match = 0; m_load = 0; m_pend = 0; m_raw = 0; m_ctrl = 0; m_pc = 0;
  endtask

  // one bus cycle: drive, advance model at the edge, check after it
  task automatic step(input logic rd, input logic wr, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp_rd, nc;
    logic tick, set;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    exp_rd = model_read(a);
    tick = m_ctrl[2] && (m_pc == DIV - 1);
    m_pc = !m_ctrl[2] ? 0 : (tick ? 0 : m_pc + 1);
    set = 1'b0;
    if (tick) begin
      if (m_pend) nc = m_load;
      else if (m_cnt == 32'hFFFF_FFFF && !m_ctrl[3]) nc = m_cnt;
      else nc = m_cnt + 1;
      m_pend = 1'b0;
      set = (nc == m_match);
      m_cnt = nc;
    end
    if (set) m_raw = 1'b1;
    else if (rd && a == 4'd6) m_raw = 1'b0;
    if (wr) begin
      if (a == 4'd1) m_match = d;
      if (a == 4'd2) begin m_load = d; m_pend = 1'b1; end
      if (a == 4'd3) m_ctrl = d[3:0];
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    if (rd) chk(tag, bus_rdata, exp_rd);
    chk("R6 irq", {31'd0, irq_o}, {31'd0, m_raw & m_ctrl[0] & ~m_ctrl[1]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 32'd0, "idle");
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b0, 1'b1, a, d, "wr");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(4'(a), "R1 reset value");
    chk("R1 irq low", {31'd0, irq_o}, 32'd0);
    // R8 version, R9 unmapped
    rd(4'd7, "R8 version");
    rd(4'd9, "R9 unmapped");
    rd(4'd15, "R9 unmapped top");

    // R2 counting
    wr(4'd3, 32'h4);
    idle(2 * DIV + 1);
    rd(4'd0, "R2 counting");
    chk("R2 literal", m_cnt, 32'd2);
    wr(4'd3, 32'h0);
    idle(3 * DIV);
    rd(4'd0, "R2 halted");
    chk("R2 halted literal", m_cnt, 32'd2);
    rd(4'd3, "R10 ctrl");

    // R3 deferred load
    wr(4'd3, 32'h4);
    wr(4'd2, 32'd100);
    rd(4'd0, "R3 old value before tick");
    rd(4'd2, "R3 load readback");
    idle(DIV);
    rd(4'd0, "R3 loaded value");

    // R4 hold at top, then wrap
    wr(4'd2, 32'hFFFF_FFFF);
    idle(3 * DIV);
    rd(4'd0, "R4 hold at top");
    chk("R4 hold literal", m_cnt, 32'hFFFF_FFFF);
    wr(4'd3, 32'hC);
    idle(DIV);
    rd(4'd0, "R4 wrap");

    // R5 raw set with alarm disabled
    wr(4'd3, 32'h4);
    wr(4'd1, m_cnt + 2);
    idle(3 * DIV);
    rd(4'd5, "R5 raw set while disabled");
    chk("R5 raw literal", {31'd0, m_raw}, 32'd1);
    rd(4'd4, "R6 masked low while disabled");
    // R6 enable then mask
    wr(4'd3, 32'h5);
    rd(4'd4, "R6 masked with enable");
    wr(4'd3, 32'h7);
    rd(4'd4, "R6 masked with mask");
    rd(4'd5, "R6 raw under mask");
    // R7 acknowledge
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd5, "R7 write to ack ignored");
    rd(4'd6, "R7 ack read returns 0");
    rd(4'd5, "R7 raw cleared");
    wr(4'd3, 32'h5);

    // R8 read-only writes ignored
    wr(4'd0, 32'h1234_5678);
    wr(4'd7, 32'h0);
    wr(4'd5, 32'h1);
    wr(4'd4, 32'h1);
    rd(4'd0, "R8 counter write ignored");
    rd(4'd7, "R8 version write ignored");
    rd(4'd5, "R8 raw write ignored");
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, "R10 ctrl upper bits zero");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 9);
      logic [3:0] a = 4'($urandom_range(0, 15));
      case (op)
        0: wr(4'd3, {$urandom} | 32'h4);
        1: wr(4'd1, m_cnt + $urandom_range(0, 3));
        2: wr(4'd2, ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF - $urandom_range(0, 2) : $urandom);
        3: wr(a, $urandom);
        4, 5: rd(a, "R9 random read");
        6: rd(4'd6, "R7 random ack");
        default: idle(1);
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule